// File: doc/BRIEF.md
# Receive Mailbox Lock Controller

This block holds a small array of receive mailboxes for a CAN-style controller. Completed frames arrive from the receive shift logic with the index of the mailbox they matched. Each frame waits in a one-deep pending slot. It is copied into its mailbox once that mailbox is free to take it. A CPU register port reads the mailbox words and writes the mailbox codes, the status flags and the interrupt enables.

A CPU read of a mailbox control word locks that mailbox while it holds a received frame. This keeps the frame stable while software copies it out. Two CPU actions remove the lock: reading the timer register, or reading the control word of another mailbox. A frame for a locked mailbox, or any frame while low-power mode is on, stays in the pending slot. A newer frame replaces it without notice.

The frame input is a valid/ready stream that never applies back-pressure. `frm_ready` is always high, and a frame is taken on every clock edge where `frm_valid` is high. The CPU port has no wait states. `cpu_rdata` reflects `cpu_addr` in the same cycle, and side effects of a read or write take effect at the clock edge that ends the access.

Top module: `rx_mbox_lock`

## Requirements
- R1: After reset every mailbox code is INACTIVE (0000), all status flags and enables are 0, `irq` is 0 and no mailbox is locked.
- R2: The control word of mailbox m sits at address 4m. It holds the code in bits [3:0], with bit 0 as the BUSY bit, and the DLC in bits [11:8]. The ID is at 4m+1, the data at 4m+2 and the timestamp at 4m+3. A control-word write takes effect only for EMPTY (0100) or INACTIVE (0000); any other code is ignored.
- R3: `frm_ready` is always 1. An accepted frame goes into a one-deep pending slot. A later frame that arrives before the move replaces the pending frame, and no error or lost-frame indication is produced.
- R4: A pending frame whose mailbox is eligible is moved in two clock edges after acceptance. The move stores ID, data, DLC and the frame's timestamp. The code becomes FULL (0010) if it was EMPTY, and OVERRUN (0110) if it was already FULL or OVERRUN.
- R5: A frame whose mailbox is INACTIVE is discarded and sets no flag.
- R6: During the cycle in which a mailbox is being written, its control word reads with BUSY = 1. A read in that cycle does not lock the mailbox.
- R7: A control-word read locks the mailbox if its code is FULL or OVERRUN and BUSY is 0. A locked mailbox is never written by a move, and its frame waits in the pending slot.
- R8: A read of the timer address 4·NUM_MB returns `timer_val` and releases any lock.
- R9: A control-word read of a mailbox other than the locked one releases the lock, and the pending frame for the formerly locked mailbox is moved in.
- R10: While `lpm_i` is 1 no move starts. A held frame moves in once `lpm_i` returns to 0.
- R11: Writing INACTIVE to a locked mailbox releases the lock and discards any pending frame for it, with no flag set.
- R12: Each move-in sets that mailbox's flag. The flags sit at address 4·NUM_MB+1 and are write-1-to-clear. The enables sit at 4·NUM_MB+2. `irq` is 1 while any flag with its enable set is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lpm_i | input | 1 | Low-power mode; holds off all moves |
| frm_valid | input | 1 | Completed frame available |
| frm_ready | output | 1 | Always 1; frame taken when valid |
| frm_mb | input | MB_W | Index of the matched mailbox |
| frm_id | input | ID_W | Frame identifier |
| frm_dlc | input | DLC_W | Data length code |
| frm_data | input | DATA_W | Frame payload |
| frm_ts | input | TS_W | Timer value captured at the second ID bit |
| timer_val | input | TS_W | Free-running timer, read at the timer address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | ADDR_W | CPU word address |
| cpu_wdata | input | REG_W | CPU write data |
| cpu_rdata | output | REG_W | CPU read data, same cycle |
| irq | output | 1 | Interrupt request |

## Verification
Frames are sent to mailboxes in every state: INACTIVE, EMPTY, FULL, locked and being written. This separates the discard, FULL, OVERRUN and hold outcomes. Each unlock path is used on its own: the timer read, a control read of another mailbox and an inactivation write. Seeing which frame finally appears shows both the release and the replacement of a pending frame by a later one. Low-power hold, a read during BUSY and a read of an EMPTY mailbox show when a read locks and when it does not.

// File: rtl/rxmb_pkg.sv
package rxmb_pkg;
  localparam logic [3:0] CODE_INACTIVE = 4'b0000;
  localparam logic [3:0] CODE_EMPTY    = 4'b0100;
  localparam logic [3:0] CODE_FULL     = 4'b0010;
  localparam logic [3:0] CODE_OVERRUN  = 4'b0110;

  typedef enum logic [1:0] {
    W_CTRL  = 2'd0,
    W_IDENT = 2'd1,
    W_DATA  = 2'd2,
    W_STAMP = 2'd3
  } word_e;

  function automatic logic holds_frame(input logic [3:0] c);
    return (c == CODE_FULL) || (c == CODE_OVERRUN);
  endfunction
endpackage

// File: rtl/rxmb_pend.sv
module rxmb_pend #(
  parameter int MB_W   = 2,
  parameter int ID_W   = 29,
  parameter int DLC_W  = 4,
  parameter int DATA_W = 32,
  parameter int TS_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_v,
  input  logic [MB_W-1:0]   in_mb,
  input  logic [ID_W-1:0]   in_id,
  input  logic [DLC_W-1:0]  in_dlc,
  input  logic [DATA_W-1:0] in_data,
  input  logic [TS_W-1:0]   in_ts,
  input  logic              take,
  output logic              pend_v,
  output logic [MB_W-1:0]   pend_mb,
  output logic [ID_W-1:0]   pend_id,
  output logic [DLC_W-1:0]  pend_dlc,
  output logic [DATA_W-1:0] pend_data,
  output logic [TS_W-1:0]   pend_ts
);
  // A newer frame always replaces the held one; no loss is reported.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_mb   <= '0;
      pend_id   <= '0;
      pend_dlc  <= '0;
      pend_data <= '0;
      pend_ts   <= '0;
    end else if (in_v) begin
      pend_v    <= 1'b1;
      pend_mb   <= in_mb;
      pend_id   <= in_id;
      pend_dlc  <= in_dlc;
      pend_data <= in_data;
      pend_ts   <= in_ts;
    end else if (take) begin
      pend_v    <= 1'b0;
    end
  end
endmodule

// File: rtl/rxmb_lock.sv
module rxmb_lock #(
  parameter int MB_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctrl_rd,
  input  logic [MB_W-1:0] rd_mb,
  input  logic            rd_lockable,
  input  logic            tmr_rd,
  input  logic            inact_wr,
  input  logic [MB_W-1:0] wr_mb,
  output logic            lock_v,
  output logic [MB_W-1:0] lock_mb,
  output logic            nxt_v,
  output logic [MB_W-1:0] nxt_mb
);
  always_comb begin
    nxt_v  = lock_v;
    nxt_mb = lock_mb;
    if (tmr_rd) nxt_v = 1'b0;
    // Reading another mailbox moves the lock (or drops it if not lockable).
    if (ctrl_rd && !(lock_v && rd_mb == lock_mb)) begin
      nxt_v  = rd_lockable;
      nxt_mb = rd_mb;
    end
    // Inactivation outranks the lock.
    if (inact_wr && nxt_v && wr_mb == nxt_mb) nxt_v = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_v  <= 1'b0;
      lock_mb <= '0;
    end else begin
      lock_v  <= nxt_v;
      lock_mb <= nxt_mb;
    end
  end
endmodule

// File: rtl/rxmb_store.sv
module rxmb_store
  import rxmb_pkg::*;
#(
  parameter int NUM_MB = 4,
  parameter int MB_W   = 2,
  parameter int ID_W   = 29,
  parameter int DLC_W  = 4,
  parameter int DATA_W = 32,
  parameter int TS_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lpm_i,
  input  logic              pend_v,
  input  logic [MB_W-1:0]   pend_mb,
  input  logic [ID_W-1:0]   pend_id,
  input  logic [DLC_W-1:0]  pend_dlc,
  input  logic [DATA_W-1:0] pend_data,
  input  logic [TS_W-1:0]   pend_ts,
  input  logic              nxt_lock_v,
  input  logic [MB_W-1:0]   nxt_lock_mb,
  input  logic              wr_code_v,
  input  logic [MB_W-1:0]   wr_mb,
  input  logic [3:0]        wr_code,
  output logic              take,
  output logic              mv_v,
  output logic [MB_W-1:0]   mv_mb,
  output logic              done,
  output logic [3:0]        code_q [NUM_MB],
  output logic [DLC_W-1:0]  dlc_q  [NUM_MB],
  output logic [ID_W-1:0]   id_q   [NUM_MB],
  output logic [DATA_W-1:0] data_q [NUM_MB],
  output logic [TS_W-1:0]   ts_q   [NUM_MB]
);
  logic              tgt_ok, blocked, go;
  logic [ID_W-1:0]   mv_id;
  logic [DLC_W-1:0]  mv_dlc;
  logic [DATA_W-1:0] mv_data;
  logic [TS_W-1:0]   mv_ts;

  always_comb begin
    tgt_ok  = int'(pend_mb) < NUM_MB;
    blocked = lpm_i || mv_v
           || (nxt_lock_v && nxt_lock_mb == pend_mb)
           || (wr_code_v && wr_mb == pend_mb);
    take    = pend_v && !blocked;
    go      = take && tgt_ok && (code_q[pend_mb] != CODE_INACTIVE);
  end

  // Second cycle of a move: a CPU code write or an inactive target cancels it.
  assign done = mv_v && !(wr_code_v && wr_mb == mv_mb)
             && (code_q[mv_mb] != CODE_INACTIVE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mv_v    <= 1'b0;
      mv_mb   <= '0;
      mv_id   <= '0;
      mv_dlc  <= '0;
      mv_data <= '0;
      mv_ts   <= '0;
    end else begin
      mv_v <= go;
      if (go) begin
        mv_mb   <= pend_mb;
        mv_id   <= pend_id;
        mv_dlc  <= pend_dlc;
        mv_data <= pend_data;
        mv_ts   <= pend_ts;
      end
    end
  end

  for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        code_q[i] <= CODE_INACTIVE;
        dlc_q[i]  <= '0;
        id_q[i]   <= '0;
        data_q[i] <= '0;
        ts_q[i]   <= '0;
      end else if (wr_code_v && wr_mb == MB_W'(i)) begin
        code_q[i] <= wr_code;
      end else if (done && mv_mb == MB_W'(i)) begin
        code_q[i] <= holds_frame(code_q[i]) ? CODE_OVERRUN : CODE_FULL;
        dlc_q[i]  <= mv_dlc;
        id_q[i]   <= mv_id;
        data_q[i] <= mv_data;
        ts_q[i]   <= mv_ts;
      end
    end
  end
endmodule

// File: rtl/rxmb_irq.sv
module rxmb_irq #(
  parameter int NUM_MB = 4,
  parameter int MB_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_v,
  input  logic [MB_W-1:0]   set_mb,
  input  logic [NUM_MB-1:0] clr_mask,
  input  logic              ien_we,
  input  logic [NUM_MB-1:0] ien_d,
  output logic [NUM_MB-1:0] flags,
  output logic [NUM_MB-1:0] ien,
  output logic              irq
);
  logic [NUM_MB-1:0] set_vec;

  assign set_vec = set_v ? (NUM_MB'(1) << set_mb) : '0;

  // Setting wins over a simultaneous clear.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      ien   <= '0;
    end else begin
      flags <= (flags & ~clr_mask) | set_vec;
      if (ien_we) ien <= ien_d;
    end
  end

  assign irq = |(flags & ien);
endmodule

// File: rtl/rx_mbox_lock.sv
module rx_mbox_lock
  import rxmb_pkg::*;
#(
  parameter int NUM_MB = 4,
  parameter int ID_W   = 29,
  parameter int DLC_W  = 4,
  parameter int DATA_W = 32,
  parameter int TS_W   = 16,
  parameter int REG_W  = 32,
  localparam int MB_W   = (NUM_MB > 1) ? $clog2(NUM_MB) : 1,
  localparam int ADDR_W = $clog2(NUM_MB * 4 + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lpm_i,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic [MB_W-1:0]   frm_mb,
  input  logic [ID_W-1:0]   frm_id,
  input  logic [DLC_W-1:0]  frm_dlc,
  input  logic [DATA_W-1:0] frm_data,
  input  logic [TS_W-1:0]   frm_ts,
  input  logic [TS_W-1:0]   timer_val,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [REG_W-1:0]  cpu_wdata,
  output logic [REG_W-1:0]  cpu_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_TMR  = ADDR_W'(NUM_MB * 4);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(NUM_MB * 4 + 1);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(NUM_MB * 4 + 2);

  logic              mb_region, ctrl_rd, ctrl_wr, tmr_rd, inact_wr, wr_code_v;
  logic              rd_lockable, busy_acc;
  logic [MB_W-1:0]   acc_mb;
  word_e             acc_w;
  logic [3:0]        wcode;

  logic              pend_v, take;
  logic [MB_W-1:0]   pend_mb;
  logic [ID_W-1:0]   pend_id;
  logic [DLC_W-1:0]  pend_dlc;
  logic [DATA_W-1:0] pend_data;
  logic [TS_W-1:0]   pend_ts;

  logic              lock_v, nxt_v;
  logic [MB_W-1:0]   lock_mb, nxt_mb;

  logic              mv_v, done;
  logic [MB_W-1:0]   mv_mb;
  logic [3:0]        code_q [NUM_MB];
  logic [DLC_W-1:0]  dlc_q  [NUM_MB];
  logic [ID_W-1:0]   id_q   [NUM_MB];
  logic [DATA_W-1:0] data_q [NUM_MB];
  logic [TS_W-1:0]   ts_q   [NUM_MB];

  logic [NUM_MB-1:0] flags, ien, flg_clr;
  logic              unused_wdata;

  assign frm_ready = 1'b1;

  // Address decode
  assign mb_region = cpu_addr < A_TMR;
  assign acc_mb    = cpu_addr[2 +: MB_W];
  assign acc_w     = word_e'(cpu_addr[1:0]);
  assign wcode     = cpu_wdata[3:0];
  assign ctrl_rd   = cpu_rd && mb_region && acc_w == W_CTRL;
  assign ctrl_wr   = cpu_wr && mb_region && acc_w == W_CTRL;
  assign tmr_rd    = cpu_rd && cpu_addr == A_TMR;
  assign wr_code_v = ctrl_wr && (wcode == CODE_EMPTY || wcode == CODE_INACTIVE);
  assign inact_wr  = ctrl_wr && wcode == CODE_INACTIVE;
  assign busy_acc  = mv_v && mv_mb == acc_mb;
  assign rd_lockable = holds_frame(code_q[acc_mb]) && !busy_acc;
  assign flg_clr   = (cpu_wr && cpu_addr == A_FLAG) ? cpu_wdata[NUM_MB-1:0] : '0;
  assign unused_wdata = ^cpu_wdata;

  rxmb_pend #(.MB_W(MB_W), .ID_W(ID_W), .DLC_W(DLC_W), .DATA_W(DATA_W), .TS_W(TS_W)) u_pend (
    .clk, .rst_n,
    .in_v(frm_valid && frm_ready), .in_mb(frm_mb), .in_id(frm_id), .in_dlc(frm_dlc),
    .in_data(frm_data), .in_ts(frm_ts), .take,
    .pend_v, .pend_mb, .pend_id, .pend_dlc, .pend_data, .pend_ts
  );

  rxmb_lock #(.MB_W(MB_W)) u_lock (
    .clk, .rst_n, .ctrl_rd, .rd_mb(acc_mb), .rd_lockable, .tmr_rd,
    .inact_wr, .wr_mb(acc_mb), .lock_v, .lock_mb, .nxt_v, .nxt_mb
  );

  rxmb_store #(.NUM_MB(NUM_MB), .MB_W(MB_W), .ID_W(ID_W), .DLC_W(DLC_W),
               .DATA_W(DATA_W), .TS_W(TS_W)) u_store (
    .clk, .rst_n, .lpm_i, .pend_v, .pend_mb, .pend_id, .pend_dlc, .pend_data, .pend_ts,
    .nxt_lock_v(nxt_v), .nxt_lock_mb(nxt_mb),
    .wr_code_v, .wr_mb(acc_mb), .wr_code(wcode),
    .take, .mv_v, .mv_mb, .done, .code_q, .dlc_q, .id_q, .data_q, .ts_q
  );

  rxmb_irq #(.NUM_MB(NUM_MB), .MB_W(MB_W)) u_irq (
    .clk, .rst_n, .set_v(done), .set_mb(mv_mb), .clr_mask(flg_clr),
    .ien_we(cpu_wr && cpu_addr == A_IEN), .ien_d(cpu_wdata[NUM_MB-1:0]),
    .flags, .ien, .irq
  );

  always_comb begin
    cpu_rdata = '0;
    if (mb_region) begin
      unique case (acc_w)
        W_CTRL: begin
          cpu_rdata[3:0]       = code_q[acc_mb] | {3'b000, busy_acc};
          cpu_rdata[8 +: DLC_W] = dlc_q[acc_mb];
        end
        W_IDENT: cpu_rdata[ID_W-1:0]   = id_q[acc_mb];
        W_DATA:  cpu_rdata[DATA_W-1:0] = data_q[acc_mb];
        W_STAMP: cpu_rdata[TS_W-1:0]   = ts_q[acc_mb];
        default: cpu_rdata = '0;
      endcase
    end else if (cpu_addr == A_TMR) begin
      cpu_rdata[TS_W-1:0] = timer_val;
    end else if (cpu_addr == A_FLAG) begin
      cpu_rdata[NUM_MB-1:0] = flags;
    end else if (cpu_addr == A_IEN) begin
      cpu_rdata[NUM_MB-1:0] = ien;
    end
  end
endmodule

// File: rtl/rxmb_checker.sv
module rxmb_checker #(
  parameter int NUM_MB = 4,
  parameter int MB_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lpm_i,
  input logic              cpu_rd,
  input logic              tmr_rd,
  input logic              mv_v,
  input logic [MB_W-1:0]   mv_mb,
  input logic              lock_v,
  input logic [MB_W-1:0]   lock_mb,
  input logic [NUM_MB-1:0] flags
);
  // R7: a mailbox under a move is never the locked one
  p_locked_untouched_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_v && lock_v) |-> (lock_mb != mv_mb));

  // R7: a lock only appears after a CPU read
  p_lock_by_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_v) |-> $past(cpu_rd));

  // R8: timer read leaves nothing locked
  p_timer_unlock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_rd |=> !lock_v);

  // R10: no move starts in low-power mode
  p_lpm_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lpm_i && !mv_v) |=> !mv_v);

  // R12: a flag rises only at the end of a move
  p_flag_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags & ~$past(flags))) |-> $past(mv_v));
endmodule

bind rx_mbox_lock rxmb_checker #(.NUM_MB(NUM_MB), .MB_W(MB_W)) u_chk (.*);

// File: tb/test_rx_mbox_lock.sv
module test_rx_mbox_lock;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lpm_i = 1'b0;
  logic        frm_valid = 1'b0;
  logic        frm_ready;
  logic [1:0]  frm_mb = '0;
  logic [28:0] frm_id = '0;
  logic [3:0]  frm_dlc = '0;
  logic [31:0] frm_data = '0;
  logic [15:0] frm_ts = '0;
  logic [15:0] timer_val = 16'hBEEF;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [4:0]  cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  localparam int TMR = 16, FLG = 17, IEN = 18;

  typedef struct {
    int          mb;
    logic [28:0] id;
    logic [31:0] data;
    logic [15:0] ts;
    logic [3:0]  dlc;
    logic [3:0]  code;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  rx_mbox_lock i_rx_mbox_lock (
    .clk, .rst_n, .lpm_i, .frm_valid, .frm_ready, .frm_mb, .frm_id, .frm_dlc,
    .frm_data, .frm_ts, .timer_val, .cpu_rd, .cpu_wr, .cpu_addr, .cpu_wdata,
    .cpu_rdata, .irq
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    cpu_rd = 1'b1; cpu_addr = 5'(a);
    #1 d = cpu_rdata;
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = 5'(a); cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: one frame on the stream input
  task automatic send(input int mb, input logic [28:0] id, input logic [31:0] data,
                      input logic [15:0] ts, input logic [3:0] dlc);
    @(negedge clk);
    frm_valid = 1'b1; frm_mb = 2'(mb); frm_id = id; frm_data = data;
    frm_ts = ts; frm_dlc = dlc;
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic expect_mb(input int mb, input logic [28:0] id, input logic [31:0] data,
                           input logic [15:0] ts, input logic [3:0] dlc, input logic [3:0] code);
    exp_t e;
    e.mb = mb; e.id = id; e.data = data; e.ts = ts; e.dlc = dlc; e.code = code;
    exp_q.push_back(e);
  endtask

  // Monitor side of the scoreboard: pops expected contents and reads them back
  task automatic drain();
    logic [31:0] d;
    exp_t e;
    waitc(4);
    while (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      rd(e.mb*4+1, d); chk($sformatf("R4 id mb%0d", e.mb), d, {3'b0, e.id});
      rd(e.mb*4+2, d); chk($sformatf("R4 data mb%0d", e.mb), d, e.data);
      rd(e.mb*4+3, d); chk($sformatf("R4 stamp mb%0d", e.mb), d, {16'b0, e.ts});
      rd(e.mb*4, d);
      chk($sformatf("R4 code mb%0d", e.mb), {28'b0, d[3:0]}, {28'b0, e.code});
      chk($sformatf("R4 dlc mb%0d", e.mb), {28'b0, d[11:8]}, {28'b0, e.dlc});
    end
    rd(TMR, d);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired got=running exp=done");
      report();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    waitc(3);
    rst_n = 1'b1;
    waitc(1);

    // R1: reset state
    rd(0, d);   chk("R1 code mb0", {28'b0, d[3:0]}, 32'h0);
    rd(FLG, d); chk("R1 flags", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R3 ready high", {31'b0, frm_ready}, 32'h1);

    // R5: frame to an INACTIVE mailbox is dropped
    send(0, 29'h0AAA, 32'h1111_1111, 16'h0010, 4'd3);
    waitc(4);
    rd(1, d);   chk("R5 id unchanged", d, 32'h0);
    rd(0, d);   chk("R5 code inactive", {28'b0, d[3:0]}, 32'h0);
    rd(FLG, d); chk("R5 no flag", d, 32'h0);

    // Activate all mailboxes
    for (int m = 0; m < 4; m++) wr(m*4, 32'h4);
    wr(IEN, 32'h1);

    // R4, R12: first delivery with interrupt
    send(0, 29'h0123_4567, 32'hDEAD_BEEF, 16'h1234, 4'd8);
    expect_mb(0, 29'h0123_4567, 32'hDEAD_BEEF, 16'h1234, 4'd8, 4'b0010);
    drain();
    rd(FLG, d); chk("R12 flag set", d, 32'h1);
    chk("R12 irq high", {31'b0, irq}, 32'h1);
    wr(FLG, 32'h1);
    rd(FLG, d); chk("R12 w1c clears", d, 32'h0);
    chk("R12 irq low", {31'b0, irq}, 32'h0);

    // R12: flag without enable
    send(1, 29'h0000_0B0B, 32'h2222_0000, 16'h0020, 4'd2);
    expect_mb(1, 29'h0000_0B0B, 32'h2222_0000, 16'h0020, 4'd2, 4'b0010);
    drain();
    rd(FLG, d); chk("R12 flag mb1", d, 32'h2);
    chk("R12 irq masked", {31'b0, irq}, 32'h0);
    wr(FLG, 32'hF);

    // R7, R3, R8: lock, replacement of the pending frame, timer unlock
    rd(0, d); chk("R7 read FULL", {28'b0, d[3:0]}, 32'h2);
    send(0, 29'h0000_0C0C, 32'h3333_3333, 16'h0030, 4'd1);
    waitc(4);
    rd(1, d); chk("R7 locked keeps id", d, 32'h0123_4567);
    send(0, 29'h0000_0D0D, 32'h4444_4444, 16'h0040, 4'd4);
    waitc(4);
    rd(1, d); chk("R7 still locked", d, 32'h0123_4567);
    rd(TMR, d); chk("R8 timer value", d, 32'h0000_BEEF);
    expect_mb(0, 29'h0000_0D0D, 32'h4444_4444, 16'h0040, 4'd4, 4'b0110);
    drain();

    // R9: reading another mailbox releases the lock
    rd(0, d); chk("R9 read OVERRUN", {28'b0, d[3:0]}, 32'h6);
    send(0, 29'h0000_0E0E, 32'h5555_5555, 16'h0050, 4'd5);
    waitc(4);
    rd(1, d); chk("R9 held while locked", d, 32'h0000_0D0D);
    rd(4, d);
    expect_mb(0, 29'h0000_0E0E, 32'h5555_5555, 16'h0050, 4'd5, 4'b0110);
    drain();

    // R10: low-power hold
    lpm_i = 1'b1;
    send(1, 29'h0000_0F0F, 32'h6666_6666, 16'h0060, 4'd6);
    waitc(6);
    rd(5, d); chk("R10 held in lpm", d, 32'h0000_0B0B);
    lpm_i = 1'b0;
    expect_mb(1, 29'h0000_0F0F, 32'h6666_6666, 16'h0060, 4'd6, 4'b0110);
    drain();

    // R7: a read of an EMPTY mailbox does not lock
    rd(8, d); chk("R7 mb2 empty", {28'b0, d[3:0]}, 32'h4);
    send(2, 29'h0000_1010, 32'h7777_7777, 16'h0070, 4'd7);
    expect_mb(2, 29'h0000_1010, 32'h7777_7777, 16'h0070, 4'd7, 4'b0010);
    drain();

    // R11: inactivation outranks the lock and drops the pending frame
    wr(FLG, 32'hF);
    rd(8, d);
    send(2, 29'h0000_1111, 32'h8888_8888, 16'h0080, 4'd2);
    waitc(4);
    rd(9, d); chk("R11 locked before write", d, 32'h0000_1010);
    wr(8, 32'h0);
    waitc(4);
    rd(9, d);   chk("R11 id unchanged", d, 32'h0000_1010);
    rd(8, d);   chk("R11 code inactive", {28'b0, d[3:0]}, 32'h0);
    rd(FLG, d); chk("R11 no flag", d, 32'h0);

    // R6: read during the write cycle shows BUSY and does not lock
    send(3, 29'h0000_1212, 32'h9999_9999, 16'h0090, 4'd3);
    rd(12, d); chk("R6 busy code", {28'b0, d[3:0]}, 32'h5);
    waitc(3);
    send(3, 29'h0000_1313, 32'hAAAA_AAAA, 16'h00A0, 4'd1);
    expect_mb(3, 29'h0000_1313, 32'hAAAA_AAAA, 16'h00A0, 4'd1, 4'b0110);
    drain();

    // R2: only EMPTY and INACTIVE codes are accepted
    wr(12, 32'h2);
    rd(12, d); chk("R2 FULL write ignored", {28'b0, d[3:0]}, 32'h6);
    wr(12, 32'h4);
    rd(12, d); chk("R2 EMPTY write taken", {28'b0, d[3:0]}, 32'h4);
    rd(TMR, d);

    finished = 1;
    report();
    $finish;
  end
endmodule